// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

This block derives two divided audio base ticks, A and B, from a small set of source clocks. Everything runs in one system clock domain. Each source arrives as a one-cycle enable pulse: input A, input B, input C and an internal clock. Each of the two generators picks one source, prescales it by 2, 8, 32 or 128, and then divides by a further count of N+1. It emits a one-cycle tick at the end of every full period. A clock-out tick follows whichever generator the control word names. The usual use is one generator for the 44.1 kHz family and the other for the 48 kHz family.

A per-port byte routes either a raw source or one of the two generator ticks to each serial audio port. A simple word-wide register port holds all settings and reads them back. Writing a divide word or the control word restarts the affected generators from a clean zero, so no shortened period reaches the outputs.

Top module: `audio_brg`

## Requirements
- R1: After reset the control word reads 0x00000000, both divide words read 0x000000FF, and every port-select word reads 0. All tick outputs are low.
- R2: The control word (address 0) keeps only the bits under 0x80770000, and the other bits read 0. The divide words (address 1 for A, address 2 for B) keep bits 9:0 only.
- R3: In a divide word, bits 9:8 hold code p, giving a prescale ratio of 2<<(2p), and bits 7:0 hold N. Each generator ticks once per ratio×(N+1) enables of its source, on the cycle after the enable that completes the period, and the tick is high for exactly one cycle.
- R4: A generator whose divide word is 0 never ticks.
- R5: Control bits 22:20 choose the source of generator A and bits 18:16 choose the source of generator B. Code 0 is input A, 1 is input B, 4 is input C and 2 is the internal clock. Any other code selects no source.
- R6: A write to a generator's divide word, or any write to the control word, clears that generator's counters. A source enable in the write cycle is not counted, and the next tick comes exactly one full period of enables after the write.
- R7: With control bit 31 at 1, clkOutTick repeats the B tick. With bit 31 at 0, it repeats the A tick.
- R8: Port k takes its select byte from the word at address 4+k/4, at bits (k mod 4)*8+7 down to (k mod 4)*8. Code 0x01 routes input A, 0x02 input B, 0x03 input C, 0x10 the A tick and 0x20 the B tick, in the same cycle. Code 0x00 and all other codes hold the port clock off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| clkInEn | input | 4 | Source enables: bit0 input A, bit1 input B, bit2 input C, bit3 internal |
| brgTickA | output | 1 | Generator A tick |
| brgTickB | output | 1 | Generator B tick |
| clkOutTick | output | 1 | Clock-out tick from the selected generator |
| portClkTick | output | NUM_PORTS | Per-port clock enables |

## Verification
The checks on tick width and silence assume that no divide word yields a period shorter than two enables. The encoding makes this so, because the smallest non-zero word gives a ratio of 2 with one count. The source check assumes that a tick is only ever preceded by some enable on clkInEn. The stimulus drives enables only at negative edges, as single pulses or in runs. Register writes also stay one cycle long and are applied at negative edges, with enables held low outside the tests that place a pulse in the write cycle on purpose.

// File: rtl/audio_brg_pkg.sv
package audio_brg_pkg;

  localparam int PRE_W  = 2;
  localparam int CNT_W  = 8;
  localparam int DIV_W  = PRE_W + CNT_W;
  localparam int PS_W   = 2 * ((1 << PRE_W) - 1) + 1;
  localparam int SRC_W  = 3;
  localparam int NUM_IN = 4;
  localparam int SEL_W  = 8;
  localparam int NUM_GEN = 2;

  localparam logic [31:0] CTRL_WMASK = 32'h8077_0000;
  localparam int OUTSEL_BIT = 31;
  localparam int SRCA_LSB   = 20;
  localparam int SRCB_LSB   = 16;
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(10'h0FF);

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_DIVA = 1;
  localparam int ADDR_DIVB = 2;
  localparam int ADDR_PORT = 4;

  localparam int IN_A   = 0;
  localparam int IN_B   = 1;
  localparam int IN_C   = 2;
  localparam int IN_INT = 3;

  localparam logic [SRC_W-1:0] GSRC_A   = 3'd0;
  localparam logic [SRC_W-1:0] GSRC_B   = 3'd1;
  localparam logic [SRC_W-1:0] GSRC_INT = 3'd2;
  localparam logic [SRC_W-1:0] GSRC_C   = 3'd4;

  localparam logic [SEL_W-1:0] PSEL_A    = 8'h01;
  localparam logic [SEL_W-1:0] PSEL_B    = 8'h02;
  localparam logic [SEL_W-1:0] PSEL_C    = 8'h03;
  localparam logic [SEL_W-1:0] PSEL_GENA = 8'h10;
  localparam logic [SEL_W-1:0] PSEL_GENB = 8'h20;

  typedef struct packed {
    logic                restartA;
    logic                restartB;
    logic                outSelB;
    logic [SRC_W-1:0]    srcA;
    logic [SRC_W-1:0]    srcB;
    logic [DIV_W-1:0]    divA;
    logic [DIV_W-1:0]    divB;
  } brg_ctl_t;

  function automatic logic pickSource(input logic [SRC_W-1:0] code,
                                      input logic [NUM_IN-1:0] en);
    case (code)
      GSRC_A:   return en[IN_A];
      GSRC_B:   return en[IN_B];
      GSRC_C:   return en[IN_C];
      GSRC_INT: return en[IN_INT];
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic pickPort(input logic [SEL_W-1:0] code,
                                    input logic [NUM_IN-1:0] en,
                                    input logic genA,
                                    input logic genB);
    case (code)
      PSEL_A:    return en[IN_A];
      PSEL_B:    return en[IN_B];
      PSEL_C:    return en[IN_C];
      PSEL_GENA: return genA;
      PSEL_GENB: return genB;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/audio_brg_divider.sv
module audio_brg_divider
  import audio_brg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             srcEn,
  input  logic [DIV_W-1:0] divWord,
  output logic             tick
);

  logic [PRE_W-1:0] preCode;
  logic [CNT_W-1:0] countLimit;
  logic [PS_W-1:0]  ratioM1;
  logic [PS_W-1:0]  psCount;
  logic [CNT_W-1:0] divCount;
  logic             active;

  assign preCode    = divWord[DIV_W-1:CNT_W];
  assign countLimit = divWord[CNT_W-1:0];
  assign ratioM1    = (PS_W'(2) << {preCode, 1'b0}) - PS_W'(1);
  assign active     = (divWord != '0);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      psCount  <= '0;
      divCount <= '0;
      tick     <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (srcEn && active) begin
        if (psCount == ratioM1) begin
          psCount <= '0;
          if (divCount == countLimit) begin
            divCount <= '0;
            tick     <= 1'b1;
          end else begin
            divCount <= divCount + CNT_W'(1);
          end
        end else begin
          psCount <= psCount + PS_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/audio_brg_ctrl.sv
module audio_brg_ctrl
  import audio_brg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_PORTS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [31:0]               regWrData,
  output logic [31:0]               regRdData,
  output brg_ctl_t                  ctlBus,
  output logic [NUM_PORTS*SEL_W-1:0] portSelFlat
);

  localparam int PER_WORD  = 32 / SEL_W;
  localparam int SEL_WORDS = (NUM_PORTS + PER_WORD - 1) / PER_WORD;

  logic [31:0]      ctrlReg;
  logic [DIV_W-1:0] divAReg;
  logic [DIV_W-1:0] divBReg;
  logic [31:0]      selWord [SEL_WORDS];

  logic hitCtrl, hitDivA, hitDivB;

  assign hitCtrl = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign hitDivA = regWrEn && (regAddr == ADDR_W'(ADDR_DIVA));
  assign hitDivB = regWrEn && (regAddr == ADDR_W'(ADDR_DIVB));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divAReg <= DIV_RESET;
      divBReg <= DIV_RESET;
    end else begin
      if (hitCtrl) ctrlReg <= regWrData & CTRL_WMASK;
      if (hitDivA) divAReg <= regWrData[DIV_W-1:0];
      if (hitDivB) divBReg <= regWrData[DIV_W-1:0];
    end
  end

  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_selWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        selWord[w] <= '0;
      end else if (regWrEn && (regAddr == ADDR_W'(ADDR_PORT + w))) begin
        selWord[w] <= regWrData;
      end
    end
  end

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_portSel
    assign portSelFlat[k*SEL_W +: SEL_W] =
      selWord[k / PER_WORD][(k % PER_WORD)*SEL_W +: SEL_W];
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) regRdData = ctrlReg;
    if (regAddr == ADDR_W'(ADDR_DIVA)) regRdData = 32'(divAReg);
    if (regAddr == ADDR_W'(ADDR_DIVB)) regRdData = 32'(divBReg);
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (regAddr == ADDR_W'(ADDR_PORT + w)) regRdData = selWord[w];
    end
  end

  always_comb begin
    ctlBus.restartA = hitCtrl || hitDivA;
    ctlBus.restartB = hitCtrl || hitDivB;
    ctlBus.outSelB  = ctrlReg[OUTSEL_BIT];
    ctlBus.srcA     = ctrlReg[SRCA_LSB +: SRC_W];
    ctlBus.srcB     = ctrlReg[SRCB_LSB +: SRC_W];
    ctlBus.divA     = divAReg;
    ctlBus.divB     = divBReg;
  end

endmodule

// File: rtl/audio_brg_datapath.sv
module audio_brg_datapath
  import audio_brg_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  brg_ctl_t                   ctlBus,
  input  logic [NUM_PORTS*SEL_W-1:0] portSelFlat,
  input  logic [NUM_IN-1:0]          clkInEn,
  output logic                       tickA,
  output logic                       tickB,
  output logic                       outTick,
  output logic [NUM_PORTS-1:0]       portTick
);

  logic [SRC_W-1:0] genSrc     [NUM_GEN];
  logic [DIV_W-1:0] genDiv     [NUM_GEN];
  logic             genRestart [NUM_GEN];
  logic [NUM_GEN-1:0] genTick;

  assign genSrc[0]     = ctlBus.srcA;
  assign genSrc[1]     = ctlBus.srcB;
  assign genDiv[0]     = ctlBus.divA;
  assign genDiv[1]     = ctlBus.divB;
  assign genRestart[0] = ctlBus.restartA;
  assign genRestart[1] = ctlBus.restartB;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic srcEn;
    assign srcEn = pickSource(genSrc[g], clkInEn);
    audio_brg_divider u_div (
      .clk     (clk),
      .rstN    (rstN),
      .restart (genRestart[g]),
      .srcEn   (srcEn),
      .divWord (genDiv[g]),
      .tick    (genTick[g])
    );
  end

  assign tickA   = genTick[0];
  assign tickB   = genTick[1];
  assign outTick = ctlBus.outSelB ? genTick[1] : genTick[0];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    assign portTick[k] = pickPort(portSelFlat[k*SEL_W +: SEL_W], clkInEn,
                                  genTick[0], genTick[1]);
  end

endmodule

// File: rtl/audio_brg.sv
module audio_brg
  import audio_brg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_IN-1:0]    clkInEn,
  output logic                 brgTickA,
  output logic                 brgTickB,
  output logic                 clkOutTick,
  output logic [NUM_PORTS-1:0] portClkTick
);

  brg_ctl_t                   ctlBus;
  logic [NUM_PORTS*SEL_W-1:0] portSelFlat;

  audio_brg_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .ctlBus      (ctlBus),
    .portSelFlat (portSelFlat)
  );

  audio_brg_datapath #(
    .NUM_PORTS (NUM_PORTS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctlBus      (ctlBus),
    .portSelFlat (portSelFlat),
    .clkInEn     (clkInEn),
    .tickA       (brgTickA),
    .tickB       (brgTickB),
    .outTick     (clkOutTick),
    .portTick    (portClkTick)
  );

endmodule

// File: rtl/audio_brg_checker.sv
module audio_brg_checker
  import audio_brg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_PORTS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [31:0]          regRdData,
  input logic [NUM_IN-1:0]    clkInEn,
  input logic                 tickA,
  input logic                 tickB,
  input logic                 outTick,
  input logic [NUM_PORTS-1:0] portTick,
  input logic                 restartA,
  input logic                 restartB,
  input logic [DIV_W-1:0]     divA,
  input logic [DIV_W-1:0]     divB
);

  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADDR_CTRL)) |-> ((regRdData & ~CTRL_WMASK) == 32'h0));

  assert_tickA_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickA |=> !tickA);

  assert_tickB_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickB |=> !tickB);

  assert_zero_divA_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divA == '0) |-> !tickA);

  assert_zero_divB_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divB == '0) |-> !tickB);

  assert_tick_needs_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tickA || tickB) |-> $past(clkInEn != '0));

  assert_restartA_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    restartA |=> !tickA);

  assert_restartB_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    restartB |=> !tickB);

  assert_clkout_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    outTick |-> (tickA || tickB));

  assert_clkout_both_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tickA && tickB) |-> outTick);

  assert_port_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((clkInEn == '0) && !tickA && !tickB) |-> (portTick == '0));

endmodule

bind audio_brg audio_brg_checker #(
  .ADDR_W    (ADDR_W),
  .NUM_PORTS (NUM_PORTS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .clkInEn   (clkInEn),
  .tickA     (brgTickA),
  .tickB     (brgTickB),
  .outTick   (clkOutTick),
  .portTick  (portClkTick),
  .restartA  (ctlBus.restartA),
  .restartB  (ctlBus.restartB),
  .divA      (ctlBus.divA),
  .divB      (ctlBus.divB)
);

// File: tb/audio_brg_tb.sv
module audio_brg_tb;

  localparam int ADDR_W    = 4;
  localparam int NUM_PORTS = 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 regWrEn = 1'b0;
  logic [ADDR_W-1:0]    regAddr = '0;
  logic [31:0]          regWrData = '0;
  logic [31:0]          regRdData;
  logic [3:0]           clkInEn = '0;
  logic                 brgTickA, brgTickB, clkOutTick;
  logic [NUM_PORTS-1:0] portClkTick;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  int cntA, cntB, cntOut, firstA, firstB;

  always #10 clk = ~clk;

  audio_brg #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .clkInEn(clkInEn),
    .brgTickA(brgTickA), .brgTickB(brgTickB), .clkOutTick(clkOutTick),
    .portClkTick(portClkTick)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ADDR_W'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr);
    #1 data = regRdData;
  endtask

  task automatic sampleTicks(input int k);
    if (brgTickA) begin cntA++; if (firstA < 0) firstA = k; end
    if (brgTickB) begin cntB++; if (firstB < 0) firstB = k; end
    if (clkOutTick) cntOut++;
  endtask

  task automatic runPulses(input logic [3:0] mask, input int n, input int gap);
    int done = 0;
    cntA = 0; cntB = 0; cntOut = 0; firstA = -1; firstB = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sampleTicks(done);
      clkInEn = mask; done++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); sampleTicks(done);
        clkInEn = '0;
      end
    end
    @(negedge clk); sampleTicks(done); clkInEn = '0;
    @(negedge clk); sampleTicks(done);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(0, d); chk("R1", "ctrl reset", d, 32'h0);
    regRead(1, d); chk("R1", "divA reset", d, 32'hFF);
    regRead(2, d); chk("R1", "divB reset", d, 32'hFF);
    regRead(4, d); chk("R1", "port word0 reset", d, 32'h0);
    regRead(5, d); chk("R1", "port word1 reset", d, 32'h0);
    chk("R1", "ticks low", {29'b0, brgTickA, brgTickB, clkOutTick}, 32'h0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    regWrite(0, 32'hFFFF_FFFF);
    regRead(0, d); chk("R2", "ctrl write mask", d, 32'h8077_0000);
    regWrite(1, 32'hFFFF_FFFF);
    regRead(1, d); chk("R2", "divA width", d, 32'h3FF);
    regWrite(2, 32'hFFFF_F000);
    regRead(2, d); chk("R2", "divB width", d, 32'h000);
    regWrite(0, 32'h0);
  endtask

  task automatic testDivide();
    regWrite(1, 32'h002);
    regWrite(2, 32'h100);
    runPulses(4'b0001, 30, 0);
    chk("R3", "p0 N2 count", cntA, 5);
    chk("R3", "p0 N2 first", firstA, 6);
    chk("R3", "p1 N0 count", cntB, 3);
    chk("R3", "p1 N0 first", firstB, 8);
    regWrite(1, 32'h201);
    runPulses(4'b0001, 130, 2);
    chk("R3", "p2 N1 sparse count", cntA, 2);
    chk("R3", "p2 N1 sparse first", firstA, 64);
    regWrite(1, 32'h300);
    runPulses(4'b0001, 128, 1);
    chk("R3", "p3 N0 count", cntA, 1);
    chk("R3", "p3 N0 first", firstA, 128);
  endtask

  task automatic testZero();
    regWrite(1, 32'h000);
    runPulses(4'b1111, 40, 0);
    chk("R4", "zero divide silent", cntA, 0);
  endtask

  task automatic testSource();
    regWrite(1, 32'h001);
    regWrite(2, 32'h001);
    regWrite(0, 32'h0014_0000);
    runPulses(4'b0001, 12, 0);
    chk("R5", "A from in B, drive in A", cntA, 0);
    chk("R5", "B from in C, drive in A", cntB, 0);
    runPulses(4'b0010, 12, 0);
    chk("R5", "A from in B", cntA, 3);
    chk("R5", "B idle on in B", cntB, 0);
    runPulses(4'b0100, 12, 0);
    chk("R5", "A idle on in C", cntA, 0);
    chk("R5", "B from in C", cntB, 3);
    regWrite(0, 32'h0020_0000);
    runPulses(4'b1000, 12, 0);
    chk("R5", "A from internal", cntA, 3);
    chk("R5", "B from in A idle on internal", cntB, 0);
    regWrite(0, 32'h0030_0000);
    runPulses(4'b1111, 12, 0);
    chk("R5", "A unused code 3", cntA, 0);
    chk("R5", "B code 0 sees in A", cntB, 3);
    regWrite(0, 32'h0);
  endtask

  task automatic writeWithPulse(input int addr, input logic [31:0] data);
    @(negedge clk);
    clkInEn = 4'b0001; regWrEn = 1'b1;
    regAddr = ADDR_W'(addr); regWrData = data;
    @(negedge clk);
    chk("R6", "no tick in write cycle", {31'b0, brgTickA}, 32'h0);
    regWrEn = 1'b0; clkInEn = '0;
  endtask

  task automatic testRestart();
    regWrite(1, 32'h002);
    runPulses(4'b0001, 4, 0);
    writeWithPulse(1, 32'h002);
    runPulses(4'b0001, 6, 0);
    chk("R6", "div write restart first", firstA, 6);
    chk("R6", "div write restart count", cntA, 1);
    runPulses(4'b0001, 4, 0);
    writeWithPulse(0, 32'h0);
    runPulses(4'b0001, 6, 0);
    chk("R6", "ctrl write restart first", firstA, 6);
    chk("R6", "ctrl write restart count", cntA, 1);
  endtask

  task automatic testClkOut();
    regWrite(1, 32'h001);
    regWrite(2, 32'h002);
    regWrite(0, 32'h0);
    runPulses(4'b0001, 24, 0);
    chk("R7", "clkout follows A", cntOut, 6);
    regWrite(0, 32'h8000_0000);
    runPulses(4'b0001, 24, 0);
    chk("R7", "clkout follows B", cntOut, 4);
    regWrite(0, 32'h0);
  endtask

  task automatic testPorts();
    logic [7:0] exp;
    int seenA = 0;
    int seenB = 0;
    regWrite(4, 32'h0003_0201);
    regWrite(5, 32'h0004_2010);
    regWrite(1, 32'h001);
    regWrite(2, 32'h002);
    @(negedge clk); clkInEn = 4'b0001;
    #1 chk("R8", "raw input A to port0", portClkTick, 8'h01);
    @(negedge clk); clkInEn = 4'b0010;
    #1 chk("R8", "raw input B to port1", portClkTick, 8'h02);
    @(negedge clk); clkInEn = 4'b0100;
    #1 chk("R8", "raw input C to port2", portClkTick, 8'h04);
    @(negedge clk); clkInEn = 4'b1000;
    #1 chk("R8", "internal not routed, code 0 off", portClkTick, 8'h00);
    regWrite(1, 32'h001);
    regWrite(2, 32'h002);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      clkInEn = (i % 2 == 0) ? 4'b0001 : 4'b0000;
      #1;
      exp = {2'b00, brgTickB, brgTickA, 3'b000, clkInEn[0]};
      if (brgTickA) seenA++;
      if (brgTickB) seenB++;
      chk("R8", "generator ticks to ports 4 and 5", portClkTick, exp);
    end
    chk("R8", "A ticks seen", seenA, 5);
    chk("R8", "B ticks seen", seenB, 3);
    regWrite(5, 32'h0);
    seenA = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      clkInEn = 4'b0000;
      #1;
      if (brgTickA) seenA++;
      chk("R8", "select 0 stops port clock", portClkTick, 8'h00);
      @(negedge clk); clkInEn = 4'b1000;
      #1 chk("R8", "internal only, ports quiet", portClkTick[7:1], 7'h0);
    end
    regWrite(0, 32'h0020_0000);
    runPulses(4'b1000, 8, 0);
    chk("R8", "A from internal still ticks", cntA, 2);
    clkInEn = '0;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMask();
    testDivide();
    testZero();
    testSource();
    testRestart();
    testClkOut();
    testPorts();
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule